// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave port that a host reaches over three wires: an active-low select, a serial clock and one shared data line. Through it the host reads and writes a small bank of 8-bit control registers. Each access is a 16-bit word sent most significant bit first. The word holds, in order, a 3-bit command, a 4-bit register index, one turnaround bit and a data byte. The register contents leave the block as one flat parallel bus for the rest of the chip.

The select, clock and data inputs are brought into a fast system clock domain through two-flop synchronizers. Both edges of the serial clock are found inside that domain. The shared line is split into three signals: an input, an output and a registered output enable. The pad that joins them sits outside the block. The host may keep select low across several words, and it may stall the serial clock at either level at any point.

Top module: `ser_reg_port`

## Requirements
- R1: After reset every register reads as 0x00, `regs_o` is all zeros and `sdo_oe_o` is low.
- R2: Command 3'b111 writes. On the 16th rising serial edge of a word, data bits 7:0 go into the register chosen by bits 12:9, and `regs_o[8*n +: 8]` shows register n.
- R3: Command 3'b110 reads. `sdo_oe_o` rises after the falling edge of pulse 8. The register byte is then driven MSB first: bit 7 is valid before rising edge 9, and each following falling edge moves to the next bit.
- R4: In a read, `sdo_oe_o` falls after the falling edge of pulse 16.
- R5: Any command other than 3'b110 and 3'b111 changes no register and never asserts `sdo_oe_o`.
- R6: If select goes high before the 16th rising edge, the write is dropped and the register keeps its value.
- R7: If select goes high during a read, `sdo_oe_o` falls within a few system cycles and no register changes.
- R8: While select stays low, pulses 17 to 32 form a complete second word. This holds for a write followed by a read, and for two writes in a row.
- R9: A pause in the serial clock, held high or held low for any time, changes neither the result nor the bit alignment of the word.
- R10: Test-only bits read 0 and cannot be written. These are bits 7:4 of register 9 and bit 7 of register 10.
- R11: Indices 11 to 15 are reserved. A write to one changes no register. A read from one drives 0x00 with the normal enable timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Data line, as seen at the input |
| sdo_o | output | 1 | Read data toward the data line |
| sdo_oe_o | output | 1 | Drive enable for the data line |
| regs_o | output | 88 | All registers, with register n at bits 8n+7:8n |

## Verification
The bench checks the read window edge by edge. A design that drove one pulse early would put data on the line during the turnaround bit. A design that released late would clash with the host on the next word. Cancellation is tested by raising select at pulse 15 of a write and at pulse 12 of a read: a design whose counter did not clear would still commit the write or keep driving the line. Back-to-back words, stalled clocks at both levels, invalid commands, reserved indices and test-only bits are each run. These catch a counter that does not wrap at 16, a counter that loses alignment during a stall, a decoder that treats any command with a leading 1 as valid, and a write mask applied in the wrong place.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int unsigned REG_W = 8;
  localparam logic [2:0] CMD_RD = 3'b110;
  localparam logic [2:0] CMD_WR = 3'b111;

  // writable bits per register; the rest are test-only
  function automatic logic [REG_W-1:0] wr_mask(input int unsigned idx);
    case (idx)
      9:       return 8'h0F;
      10:      return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/ser_reg_sync.sv
module ser_reg_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ser_reg_frame.sv
module ser_reg_frame
  import ser_reg_pkg::*;
#(
  parameter int unsigned FW = 16,
  parameter int unsigned CW = 3,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          sclk_s_i,
  input  logic          sdi_s_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdo_o,
  output logic          oe_o
);
  localparam int unsigned HDR = CW + AW + 1;  // pulse carrying the turnaround bit
  localparam int unsigned PW  = $clog2(FW + 1);

  logic          sclk_d_q;
  logic [PW-1:0] pos_q;
  logic [FW-2:0] sh_q;
  logic [DW-1:0] rd_sh_q;
  logic          sdo_q, oe_q;
  logic          rise, fall;
  logic [CW-1:0] hdr_cmd, wr_cmd;

  assign rise = sclk_s_i & ~sclk_d_q;
  assign fall = ~sclk_s_i & sclk_d_q;

  assign hdr_cmd   = sh_q[HDR-1 -: CW];
  assign rd_addr_o = sh_q[HDR-1-CW -: AW];

  assign wr_cmd    = sh_q[FW-2 -: CW];
  assign wr_addr_o = sh_q[FW-2-CW -: AW];
  assign wr_data_o = {sh_q[DW-2:0], sdi_s_i};
  assign wr_en_o   = !cs_s_i && rise && (pos_q == PW'(FW - 1)) && (wr_cmd == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      sh_q  <= '0;
    end else if (cs_s_i) begin
      pos_q <= '0;
    end else if (rise) begin
      sh_q  <= {sh_q[FW-3:0], sdi_s_i};
      pos_q <= (pos_q == PW'(FW)) ? PW'(1) : pos_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q    <= 1'b0;
      sdo_q   <= 1'b0;
      rd_sh_q <= '0;
    end else if (cs_s_i) begin
      oe_q <= 1'b0;
    end else if (fall) begin
      if (pos_q == PW'(HDR) && hdr_cmd == CMD_RD) begin
        oe_q    <= 1'b1;
        sdo_q   <= rd_data_i[DW-1];
        rd_sh_q <= rd_data_i << 1;
      end else if (pos_q == PW'(FW)) begin
        oe_q <= 1'b0;
      end else if (oe_q) begin
        sdo_q   <= rd_sh_q[DW-1];
        rd_sh_q <= rd_sh_q << 1;
      end
    end
  end

  assign sdo_o = sdo_q;
  assign oe_o  = oe_q;

  a_r3_drive_starts_after_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> (pos_q == PW'(HDR)));
  a_r4_release_on_edge_or_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_q) |-> ($past(cs_s_i) || ($past(fall) && $past(pos_q) == PW'(FW))));
  a_r7_cs_high_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !oe_q);
  a_r8_pos_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= PW'(FW));
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank
  import ser_reg_pkg::*;
#(
  parameter int unsigned NREG = 11,
  parameter int unsigned AW   = 4,
  parameter int unsigned DW   = REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     regs_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(i))         regs_q[i] <= wr_data_i & wr_mask(i);
    end
    assign regs_o[i*DW +: DW] = regs_q[i];

    a_r2_change_needs_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(regs_q[i]) |-> $past(wr_en_i));
  end

  // reserved indices fall through to zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = regs_q[i];
  end

  a_r11_reserved_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= AW'(NREG)) |=> $stable(regs_o));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_reg_pkg::*;
#(
  parameter int unsigned NREG = 11,
  parameter int unsigned AW   = 4,
  parameter int unsigned CW   = 3,
  parameter int unsigned DW   = REG_W,
  localparam int unsigned FW  = CW + AW + 1 + DW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic cs_s, sclk_s, sdi_s;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  ser_reg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, sdi_i}),
    .q_o    ({cs_s, sclk_s, sdi_s})
  );

  ser_reg_frame #(.FW(FW), .CW(CW), .AW(AW), .DW(DW)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (cs_s),
    .sclk_s_i  (sclk_s),
    .sdi_s_i   (sdi_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sdo_o     (sdo_o),
    .oe_o      (sdo_oe_o)
  );

  ser_reg_bank #(.NREG(NREG), .AW(AW), .DW(DW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );
endmodule

// File: tb/ser_reg_port_tb.sv
module ser_reg_port_tb;
  localparam int HALF = 6;
  localparam int NV   = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, oe;
  logic [87:0] regs;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ser_reg_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk),
    .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(oe), .regs_o(regs)
  );

  // {word, expected read byte, expected enable per pulse, check read byte}
  localparam logic [40:0] TBL [NV] = '{
    {16'hE0A5, 8'h00, 16'h0000, 1'b0},  // R2 write r0
    {16'hE63C, 8'h00, 16'h0000, 1'b0},  // R2 write r3
    {16'hF2FF, 8'h00, 16'h0000, 1'b0},  // R10 write r9
    {16'hF4FF, 8'h00, 16'h0000, 1'b0},  // R10 write r10
    {16'hF677, 8'h00, 16'h0000, 1'b0},  // R11 write reserved
    {16'hC000, 8'hA5, 16'hFF00, 1'b1},  // R3 read r0
    {16'hC600, 8'h3C, 16'hFF00, 1'b1},  // R3 read r3
    {16'hD200, 8'h0F, 16'hFF00, 1'b1},  // R10 read r9
    {16'hD400, 8'h7F, 16'hFF00, 1'b1},  // R10 read r10
    {16'hD600, 8'h00, 16'hFF00, 1'b1},  // R11 read reserved
    {16'hA000, 8'h00, 16'h0000, 1'b0},  // R5 cmd 101
    {16'h865A, 8'h00, 16'h0000, 1'b0},  // R5 cmd 100
    {16'h60FF, 8'h00, 16'h0000, 1'b0},  // R5 cmd 011
    {16'hC000, 8'hA5, 16'hFF00, 1'b1}   // R5 r0 untouched
  };

  task automatic chk(input bit ok, input string req, input logic [87:0] act, input logic [87:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    cs_ni = 1'b0;
    wait_n(HALF);
  endtask

  task automatic cs_hi();
    cs_ni = 1'b1;
    wait_n(HALF + 2);
  endtask

  task automatic run_frame(input logic [15:0] w, input int npulse, input int pause_at,
                           output logic [7:0] rd, output logic [15:0] oe_seen, output logic oe_end);
    rd = '0;
    oe_seen = '0;
    for (int i = 0; i < npulse; i++) begin
      sdi = w[15-i];
      wait_n(HALF);
      oe_seen[i] = oe;
      if (i >= 8) rd[15-i] = sdo;
      sclk = 1'b1;
      wait_n(HALF);
      if (i == pause_at) wait_n(150);
      sclk = 1'b0;
      if (i == pause_at) wait_n(150);
    end
    wait_n(HALF);
    oe_end = oe;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic [15:0] oes;
    logic oe_end;
    logic [87:0] snap;

    wait_n(4);
    rst_ni = 1'b1;
    wait_n(4);
    // R1 reset state
    chk(regs == '0, "R1 regs", regs, 88'h0);
    chk(oe == 1'b0, "R1 oe", {87'h0, oe}, 88'h0);

    for (int v = 0; v < NV; v++) begin
      snap = regs;
      cs_lo();
      run_frame(TBL[v][40:25], 16, -1, rd, oes, oe_end);
      cs_hi();
      chk(oes == TBL[v][16:1], "R3/R5 enable window", {72'h0, oes}, {72'h0, TBL[v][16:1]});
      chk(oe_end == 1'b0, "R4 release", {87'h0, oe_end}, 88'h0);
      if (TBL[v][0])
        chk(rd == TBL[v][24:17], "R3 read data", {80'h0, rd}, {80'h0, TBL[v][24:17]});
      if (v == 4 || v >= 10)
        chk(regs == snap, "R11/R5 no change", regs, snap);
    end
    chk(regs[7:0] == 8'hA5, "R2 r0", {80'h0, regs[7:0]}, 88'hA5);
    chk(regs[31:24] == 8'h3C, "R2 r3", {80'h0, regs[31:24]}, 88'h3C);
    chk(regs[79:72] == 8'h0F, "R10 r9", {80'h0, regs[79:72]}, 88'h0F);
    chk(regs[87:80] == 8'h7F, "R10 r10", {80'h0, regs[87:80]}, 88'h7F);

    // R6 cancel write at pulse 15
    cs_lo();
    run_frame(16'hE255, 15, -1, rd, oes, oe_end);
    cs_hi();
    chk(regs[15:8] == 8'h00, "R6 cancelled write", {80'h0, regs[15:8]}, 88'h0);
    // R6 counter restarts cleanly after cancel
    cs_lo();
    run_frame(16'hE255, 16, -1, rd, oes, oe_end);
    cs_hi();
    chk(regs[15:8] == 8'h55, "R6 write after cancel", {80'h0, regs[15:8]}, 88'h55);

    // R7 cancel read at pulse 12
    snap = regs;
    cs_lo();
    run_frame(16'hC000, 12, -1, rd, oes, oe_end);
    chk(oe_end == 1'b1, "R7 driving before cancel", {87'h0, oe_end}, 88'h1);
    cs_ni = 1'b1;
    wait_n(5);
    chk(oe == 1'b0, "R7 released on cs", {87'h0, oe}, 88'h0);
    wait_n(HALF);
    chk(regs == snap, "R7 no change", regs, snap);

    // R8 write then read in one select window
    cs_lo();
    run_frame(16'hE411, 16, -1, rd, oes, oe_end);
    run_frame(16'hC400, 16, -1, rd, oes, oe_end);
    cs_hi();
    chk(rd == 8'h11, "R8 second word read", {80'h0, rd}, 88'h11);
    chk(oes == 16'hFF00, "R8 second word window", {72'h0, oes}, 88'hFF00);
    // R8 two writes in a row
    cs_lo();
    run_frame(16'hE899, 16, -1, rd, oes, oe_end);
    run_frame(16'hEAE7, 16, -1, rd, oes, oe_end);
    cs_hi();
    chk(regs[39:32] == 8'h99 && regs[47:40] == 8'hE7, "R8 two writes",
        {72'h0, regs[47:32]}, 88'hE799);

    // R9 stalls at both levels inside a write and a read
    cs_lo();
    run_frame(16'hECC3, 16, 4, rd, oes, oe_end);
    cs_hi();
    chk(regs[55:48] == 8'hC3, "R9 stalled write", {80'h0, regs[55:48]}, 88'hC3);
    cs_lo();
    run_frame(16'hCC00, 16, 11, rd, oes, oe_end);
    cs_hi();
    chk(rd == 8'hC3, "R9 stalled read", {80'h0, rd}, 88'hC3);
    chk(oes == 16'hFF00, "R9 stalled window", {72'h0, oes}, 88'hFF00);

    finish_run();
  end
endmodule